// File: doc/BRIEF.md
# SPI Pin Ownership Arbiter

This block sits between one set of SPI flash pins and two controllers that might drive them. The first is a boot read engine that serves memory-mapped flash reads. The second is a register-driven queued master used for general SPI transfers. A one-bit control register chooses the owner. A busy status bit reports whether the boot engine still has a read outstanding.

Handing the pins to the queued master is only allowed at a safe point. If the boot engine is mid-read, the request is parked and applied once the read completes. After each handover the pins stay idle for a settle interval, and only then is the queued master told it may start.

Memory-mapped reads are screened before they reach the boot engine. A read is rejected with an error pulse if any of these hold:
- it would run past the 32 MB flash window;
- the master owns the pins;
- a handover is pending;
- another read is in flight.

Handing the pins back to the boot engine takes effect on the next clock. It also cancels any parked request.

Top module: `spi_pin_owner`

## Requirements
- R1: After reset the boot engine owns the pins. `ctl_rdata` = 0, `busy_rdata` = 0, `mst_ready` = 0, and no `rd_err` or `eng_start` pulse is given.
- R2: A control write of 1 while no boot read is in flight moves ownership to the queued master at the next clock edge. `ctl_rdata` reads 1 (1 = queued master, 0 = boot engine) from that edge on.
- R3: A control write of 1 while `busy_rdata` = 1 is held pending, and `ctl_rdata` stays 0. The switch happens at the first clock edge at which the busy flag, as it stood before that edge, is 0. This is one cycle after `busy_rdata` falls.
- R4: A control write of 0 returns ownership to the boot engine at the next clock edge from any state. It cancels a pending switch, and `mst_ready` drops at the same edge.
- R5: `mst_ready` rises exactly SETTLE_CYC clock cycles after `ctl_rdata` rises. The default is 10 cycles, which is 200 ns at 50 MHz. A further control write of 1 while the master already owns the pins does not restart this count.
- R6: An accepted mapped read gives a one-cycle `eng_start` pulse one clock after the request, carrying the request's offset and length. `busy_rdata` is 1 from that edge until the edge after `eng_done` is seen. An `eng_done` while not busy has no effect.
- R7: A mapped read is accepted only when offset + length <= 2^25 bytes. A read that ends exactly at the window edge is accepted. One that goes a single byte past it gets a `rd_err` pulse one clock later and no `eng_start`.
- R8: A mapped read that arrives in any of the following cases gets `rd_err`, and leaves ownership, busy status and the pins untouched:
  - the master owns the pins;
  - a switch is pending;
  - a read is in flight;
  - a control write of 1 arrives in the same cycle.
- R9: The SPI pins follow a fixed rule:
  - while the boot engine owns them, they follow the boot engine's pins;
  - while the master owns them and `mst_ready` = 1, they follow the master's pins;
  - while the master owns them and the settle interval is still running, they sit idle with `spi_cs_n` = 1, `spi_sck` = 0 and `spi_mosi` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 1 | Owner request: 1 = queued master, 0 = boot engine |
| ctl_rdata | output | 1 | Owner in effect |
| busy_rdata | output | 1 | Boot engine read in flight |
| rd_req | input | 1 | Memory-mapped read request, one cycle |
| rd_off | input | OFF_W (26) | Byte offset into the flash window |
| rd_len | input | LEN_W (16) | Read length in bytes |
| rd_err | output | 1 | Error response for a rejected read, one cycle |
| eng_start | output | 1 | Start pulse to the boot engine |
| eng_off | output | OFF_W (26) | Offset handed to the boot engine |
| eng_len | output | LEN_W (16) | Length handed to the boot engine |
| eng_done | input | 1 | Boot engine has finished its read |
| mst_ready | output | 1 | Queued master owns settled pins |
| boot_sck | input | 1 | Boot engine clock pin |
| boot_cs_n | input | 1 | Boot engine chip select |
| boot_mosi | input | 1 | Boot engine data out |
| mst_sck | input | 1 | Queued master clock pin |
| mst_cs_n | input | 1 | Queued master chip select |
| mst_mosi | input | 1 | Queued master data out |
| spi_sck | output | 1 | SPI clock pin |
| spi_cs_n | output | 1 | SPI chip select pin |
| spi_mosi | output | 1 | SPI data out pin |

## Verification
The bench targets the following corner cases:
- **Switch while busy.** A design that ignored busy would snatch the pins mid-read. One that dropped the parked request would never hand over at all.
- **Off-by-one in the settle count.** This would release the master a cycle early or late.
- **Write of 1 while already master.** A design that restarted the settle count here would blank the pins.
- **Window boundary: exact fit versus one byte over.** A wrong comparison would either cut off the last legal read or let a read run past the window.
- **Read colliding with a same-cycle switch, and write of 0 during a pending switch.** A design that got these wrong would start a read behind the master's back, or switch after being told not to.

// File: rtl/spi_own_pkg.sv
package spi_own_pkg;
  typedef enum logic {OWN_BOOT = 1'b0, OWN_MST = 1'b1} owner_e;

  typedef struct packed {
    logic sck;
    logic cs_n;
    logic mosi;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/spi_own_fsm.sv
module spi_own_fsm
  import spi_own_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ctl_we_i,
  input  logic   ctl_wdata_i,
  input  logic   busy_i,
  output owner_e owner_o,
  output logic   pend_o,
  output logic   take_mst_o,
  output logic   drop_o
);
  owner_e owner_q;
  logic   pend_q;
  logic   req_mst, hold;

  // Events, brought out as named wires for the checks
  assign req_mst    = ctl_we_i && ctl_wdata_i;
  assign drop_o     = ctl_we_i && !ctl_wdata_i;
  assign hold       = req_mst && (owner_q == OWN_BOOT) && busy_i;
  assign take_mst_o = !drop_o && !busy_i &&
                      ((req_mst && owner_q == OWN_BOOT) || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_BOOT;
      pend_q  <= 1'b0;
    end else if (drop_o) begin
      owner_q <= OWN_BOOT;
      pend_q  <= 1'b0;
    end else if (take_mst_o) begin
      owner_q <= OWN_MST;
      pend_q  <= 1'b0;
    end else if (hold) begin
      pend_q  <= 1'b1;
    end
  end

  assign owner_o = owner_q;
  assign pend_o  = pend_q;

  // R3: the master never gains the pins while a boot read is in flight
  a_r3_switch_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owner_q) |-> !$past(busy_i));

  // R4: a write of 0 always lands on the boot engine with nothing pending
  a_r4_drop_to_boot: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> (owner_q == OWN_BOOT) && !pend_q);

  // R3: a pending request only exists while the boot engine holds the pins
  a_r3_pend_only_boot: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> owner_q == OWN_BOOT);
endmodule

// File: rtl/spi_settle_timer.sv
module spi_settle_timer #(
  parameter int SETTLE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clear_i,
  output logic ready_o
);
  localparam int CNT_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= LOAD;
      armed_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign ready_o = armed_q && (cnt_q == '0);

  // R5: once ready, stays ready until cleared
  a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !clear_i && !start_i) |=> ready_o);
endmodule

// File: rtl/spi_rd_gate.sv
module spi_rd_gate
  import spi_own_pkg::*;
#(
  parameter int OFF_W    = 26,
  parameter int LEN_W    = 16,
  parameter int WIN_LOG2 = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req_i,
  input  logic [OFF_W-1:0] rd_off_i,
  input  logic [LEN_W-1:0] rd_len_i,
  input  owner_e           owner_i,
  input  logic             pend_i,
  input  logic             sw_req_i,
  input  logic             eng_done_i,
  output logic             eng_start_o,
  output logic [OFF_W-1:0] eng_off_o,
  output logic [LEN_W-1:0] eng_len_o,
  output logic             rd_err_o,
  output logic             busy_o
);
  localparam int SUM_W = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 1;
  localparam logic [SUM_W-1:0] WIN_LIM = SUM_W'(1) << WIN_LOG2;

  function automatic logic in_window(input logic [OFF_W-1:0] off,
                                     input logic [LEN_W-1:0] len);
    logic [SUM_W-1:0] last;
    last = SUM_W'(off) + SUM_W'(len);
    return last <= WIN_LIM;
  endfunction

  logic busy_q, start_q, err_q;
  logic [OFF_W-1:0] off_q;
  logic [LEN_W-1:0] len_q;
  logic fits, free, accept, reject;

  assign fits   = in_window(rd_off_i, rd_len_i);
  assign free   = (owner_i == OWN_BOOT) && !pend_i && !busy_q && !sw_req_i;
  assign accept = rd_req_i && free && fits;
  assign reject = rd_req_i && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
      off_q   <= '0;
      len_q   <= '0;
    end else begin
      start_q <= accept;
      err_q   <= reject;
      if (accept) begin
        off_q  <= rd_off_i;
        len_q  <= rd_len_i;
        busy_q <= 1'b1;
      end else if (eng_done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign eng_start_o = start_q;
  assign eng_off_o   = off_q;
  assign eng_len_o   = len_q;
  assign rd_err_o    = err_q;
  assign busy_o      = busy_q;

  // R6: a start pulse always comes with the busy flag raised
  a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q);

  // R8: a request is either accepted or rejected, never both
  a_r8_err_xor_start: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && err_q));

  // R6: a request always gets exactly one response on the next cycle
  a_r6_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> (start_q || err_q));
endmodule

// File: rtl/spi_pin_owner.sv
module spi_pin_owner
  import spi_own_pkg::*;
#(
  parameter int OFF_W      = 26,
  parameter int LEN_W      = 16,
  parameter int WIN_LOG2   = 25,
  parameter int SETTLE_CYC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_wdata,
  output logic             ctl_rdata,
  output logic             busy_rdata,
  input  logic             rd_req,
  input  logic [OFF_W-1:0] rd_off,
  input  logic [LEN_W-1:0] rd_len,
  output logic             rd_err,
  output logic             eng_start,
  output logic [OFF_W-1:0] eng_off,
  output logic [LEN_W-1:0] eng_len,
  input  logic             eng_done,
  output logic             mst_ready,
  input  logic             boot_sck,
  input  logic             boot_cs_n,
  input  logic             boot_mosi,
  input  logic             mst_sck,
  input  logic             mst_cs_n,
  input  logic             mst_mosi,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi
);
  owner_e owner;
  logic   pend, take_mst, drop, busy, ready;
  pins_t  boot_p, mst_p, pins;

  spi_own_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we_i   (ctl_we),
    .ctl_wdata_i(ctl_wdata),
    .busy_i     (busy),
    .owner_o    (owner),
    .pend_o     (pend),
    .take_mst_o (take_mst),
    .drop_o     (drop)
  );

  spi_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(take_mst),
    .clear_i(drop),
    .ready_o(ready)
  );

  spi_rd_gate #(.OFF_W(OFF_W), .LEN_W(LEN_W), .WIN_LOG2(WIN_LOG2)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_i   (rd_req),
    .rd_off_i   (rd_off),
    .rd_len_i   (rd_len),
    .owner_i    (owner),
    .pend_i     (pend),
    .sw_req_i   (ctl_we && ctl_wdata),
    .eng_done_i (eng_done),
    .eng_start_o(eng_start),
    .eng_off_o  (eng_off),
    .eng_len_o  (eng_len),
    .rd_err_o   (rd_err),
    .busy_o     (busy)
  );

  assign boot_p = '{sck: boot_sck, cs_n: boot_cs_n, mosi: boot_mosi};
  assign mst_p  = '{sck: mst_sck,  cs_n: mst_cs_n,  mosi: mst_mosi};

  always_comb begin
    if (owner == OWN_BOOT) pins = boot_p;
    else if (ready)        pins = mst_p;
    else                   pins = PINS_IDLE;
  end

  assign spi_sck    = pins.sck;
  assign spi_cs_n   = pins.cs_n;
  assign spi_mosi   = pins.mosi;
  assign ctl_rdata  = (owner == OWN_MST);
  assign busy_rdata = busy;
  assign mst_ready  = ready && (owner == OWN_MST);

  // R5: the master is never ready in the cycle ownership arrives
  a_r5_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((SETTLE_CYC > 0) && $rose(ctl_rdata)) |-> !mst_ready);

  // R4: a write of 0 removes master readiness at the next edge
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata) |=> !mst_ready);

  // R9: an unsettled master sees the chip select held high
  a_r9_idle_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata && !mst_ready) |-> spi_cs_n);
endmodule

// File: tb/spi_pin_owner_tb.sv
module spi_pin_owner_tb;
  localparam int OFF_W = 26;
  localparam int LEN_W = 16;
  localparam int SETTLE = 10;
  localparam longint WIN = 64'd33554432;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, ctl_wdata = 0, rd_req = 0, eng_done = 0;
  logic [OFF_W-1:0] rd_off = '0;
  logic [LEN_W-1:0] rd_len = '0;
  logic boot_sck = 0, boot_cs_n = 1, boot_mosi = 0;
  logic mst_sck = 0, mst_cs_n = 1, mst_mosi = 0;
  logic ctl_rdata, busy_rdata, rd_err, eng_start, mst_ready;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic [OFF_W-1:0] eng_off;
  logic [LEN_W-1:0] eng_len;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_pin_owner u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .busy_rdata(busy_rdata), .rd_req(rd_req),
    .rd_off(rd_off), .rd_len(rd_len), .rd_err(rd_err), .eng_start(eng_start),
    .eng_off(eng_off), .eng_len(eng_len), .eng_done(eng_done),
    .mst_ready(mst_ready), .boot_sck(boot_sck), .boot_cs_n(boot_cs_n),
    .boot_mosi(boot_mosi), .mst_sck(mst_sck), .mst_cs_n(mst_cs_n),
    .mst_mosi(mst_mosi), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi)
  );

  // Behavioural reference model
  bit m_owner, m_pend, m_busy, m_err, m_start;
  int m_since;
  longint m_off, m_len;

  always @(posedge clk) begin
    bit sw1, fits, acc, old_busy;
    if (!rst_n) begin
      m_owner = 0; m_pend = 0; m_busy = 0; m_err = 0; m_start = 0; m_since = 0;
    end else begin
      sw1 = ctl_we && ctl_wdata;
      fits = (longint'(rd_off) + longint'(rd_len)) <= WIN;
      acc = rd_req && !m_owner && !m_pend && !m_busy && !sw1 && fits;
      m_err = rd_req && !acc;
      m_start = acc;
      if (acc) begin m_off = longint'(rd_off); m_len = longint'(rd_len); end
      old_busy = m_busy;
      if (acc) m_busy = 1;
      else if (eng_done) m_busy = 0;
      if (ctl_we && !ctl_wdata) begin
        m_owner = 0; m_pend = 0;
      end else if (!m_owner && (sw1 || m_pend)) begin
        if (old_busy) m_pend = 1;
        else begin m_owner = 1; m_pend = 0; m_since = 0; end
      end else if (m_owner && m_since < SETTLE) begin
        m_since++;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit rdy;
    logic [2:0] ep, ap;
    #5;
    rdy = m_owner && (m_since >= SETTLE);
    if (!m_owner) ep = {boot_sck, boot_cs_n, boot_mosi};
    else if (rdy) ep = {mst_sck, mst_cs_n, mst_mosi};
    else ep = 3'b010;
    ap = {spi_sck, spi_cs_n, spi_mosi};
    chk("R1/R2/R3/R4 ctl_rdata owner", longint'(ctl_rdata), longint'(m_owner));
    chk("R6 busy_rdata", longint'(busy_rdata), longint'(m_busy));
    chk("R5 mst_ready", longint'(mst_ready), longint'(rdy));
    chk("R7/R8 rd_err", longint'(rd_err), longint'(m_err));
    chk("R6/R8 eng_start", longint'(eng_start), longint'(m_start));
    if (m_start) begin
      chk("R6 eng_off", longint'(eng_off), m_off);
      chk("R6 eng_len", longint'(eng_len), m_len);
    end
    chk("R9 spi pins", longint'(ap), longint'(ep));
  end

  // Pin activity from both controllers
  initial begin
    forever begin
      @(negedge clk);
      {boot_sck, boot_cs_n, boot_mosi, mst_sck, mst_cs_n, mst_mosi} = 6'($urandom);
    end
  end

  task automatic cyc(input bit we, input bit wd, input bit req,
                     input longint off, input longint len, input bit dn);
    @(negedge clk);
    ctl_we = we; ctl_wdata = wd; rd_req = req;
    rd_off = OFF_W'(off); rd_len = LEN_W'(len); eng_done = dn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    idle(3);                           // R1 reset state checked each cycle
    @(negedge clk); rst_n = 1;
    idle(2);
    cyc(0, 0, 1, 0, 16, 0); idle(3);   // R6 accepted read
    cyc(0, 0, 0, 0, 0, 1); idle(2);
    cyc(0, 0, 1, WIN - 4, 4, 0); idle(1); cyc(0, 0, 0, 0, 0, 1); idle(1);  // R7 exact fit
    cyc(0, 0, 1, WIN - 4, 5, 0); idle(2);                                   // R7 one over
    cyc(0, 0, 1, WIN, 0, 0); cyc(0, 0, 0, 0, 0, 1); idle(1);
    cyc(0, 0, 1, 2 * WIN - 1, 1, 0); idle(2);
    cyc(1, 1, 0, 0, 0, 0); idle(4);    // R2 switch
    cyc(1, 1, 0, 0, 0, 0); idle(3);    // R5 rewrite does not restart
    cyc(0, 0, 1, 0, 8, 0); idle(6);    // R8 read under master
    cyc(1, 0, 0, 0, 0, 0); idle(2);    // R4 return
    cyc(0, 0, 1, 64, 32, 0);           // R3 pending while busy
    cyc(1, 1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 4, 0); idle(3);    // R8 read while busy/pending
    cyc(0, 0, 0, 0, 0, 1); idle(14);
    cyc(1, 0, 0, 0, 0, 0); idle(1);
    cyc(0, 0, 1, 128, 2, 0); cyc(1, 1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0);  // R4 cancel
    idle(2); cyc(0, 0, 0, 0, 0, 1); idle(3);
    cyc(1, 1, 1, 0, 4, 0); idle(12);   // R8 same-cycle switch
    cyc(1, 0, 0, 0, 0, 1); idle(2);    // R6 stray done
    for (int i = 0; i < 3000; i++) begin
      int r;
      longint off;
      r = int'($urandom % 100);
      off = (r < 50) ? (WIN - longint'($urandom % 40)) : longint'($urandom % 64'd67108864);
      cyc(($urandom % 14) == 0, $urandom % 2, ($urandom % 5) == 0,
          off, longint'($urandom % 48), ($urandom % 7) == 0);
    end
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule